// File: doc/BRIEF.md
# Three-Path Instruction Decode Selector

This block sits between an instruction window and the scheduler of a processor front end. Each clock it looks at the two oldest pre-classified instructions in the window. Each instruction arrives with a byte length, a frequency class and a small opcode tag. From these the block picks one decode path for the whole clock: short, long or vector. It then turns the selected instruction or instructions into one group of exactly four micro-operations. Any slot that the decode leaves empty holds a NOP.

The short path is the only one that can take two instructions in one clock. The long path and the vector path take one instruction each. Micro-operations come from a small template rule keyed by the opcode tag. Each finished group goes into an internal queue of six groups, which is 24 micro-operations in all. The scheduler drains that queue through a valid/ready output port.

Back-pressure rules:
- A group is transferred on a clock edge where `out_valid` and `out_ready` are both high.
- While `out_ready` is low, the head group stays unchanged.
- On the input side, an entry is consumed on an edge where its valid and its ready are both high.
- While the queue holds six groups, both input readies are low. Nothing is consumed, whatever the scheduler does in that same clock.

Top module: `mpath_decode_sel`

## Requirements
- R1: Path selection and short-path op count. An instruction of class common (code 0) with a length from 1 to 7 takes the short path (out_path code 0). It produces min(tag[1:0], 2) micro-ops, so a short decode can produce zero ops.
- R2: Pairing. When both entries are valid and both qualify for the short path, both are consumed in one clock. Entry 0's micro-ops fill the lowest slots. Entry 1's micro-ops follow directly above them.
- R3: Single decode. When entry 1 does not qualify for the short path, or entry 0 does not, `in1_ready` is low and only entry 0 is decoded that clock.
- R4: Long path (out_path code 1). It is taken by a common instruction of length 8 to 11, and by a semi-common instruction (class code 1) of length 1 to 7. It produces tag[1:0]+1 micro-ops.
- R5: Vector path (out_path code 2). It is taken by every other case: class complex (code 2), class serializing (code 3), length 0, length above 11, and semi-common above 7. It produces four micro-ops, each flagged as sequenced.
- R6: Micro-op encoding and padding. Micro-op k (counting from 0) of an instruction with tag t is {1, v, t, k}, where v is 1 only on the vector path. Slot s sits at out_ops bits [8s+7:8s]. Every unused slot holds NOP, which is 8'h00.
- R7: Capacity and stall. The queue holds up to six groups. While six are held, in0_ready and in1_ready are low and no window entry is consumed.
- R8: Output handshake. Groups leave in the order they were formed. A group held under back-pressure keeps its out_ops and out_path unchanged.
- R9: After reset the queue is empty, out_valid is low and in0_ready is high.
- R10: Entry 1 is ignored while in0_valid is low. No group is formed and in1_ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in0_valid | input | 1 | Oldest window entry present |
| in0_len | input | 4 | Entry 0 length in bytes |
| in0_cls | input | 2 | Entry 0 class: 0 common, 1 semi-common, 2 complex, 3 serializing |
| in0_tag | input | 4 | Entry 0 opcode tag |
| in0_ready | output | 1 | Entry 0 consumed this clock if valid |
| in1_valid | input | 1 | Second window entry present |
| in1_len | input | 4 | Entry 1 length in bytes |
| in1_cls | input | 2 | Entry 1 class |
| in1_tag | input | 4 | Entry 1 opcode tag |
| in1_ready | output | 1 | Entry 1 consumed this clock (paired short decode) |
| out_valid | output | 1 | Head group available |
| out_ready | input | 1 | Scheduler accepts the head group |
| out_ops | output | 32 | Four micro-op slots, slot 0 in the low byte |
| out_path | output | 2 | Path that formed the head group |

## Verification
The state that is hardest to reach from the ports is a full queue with a window entry still waiting. In that state the stall has to hold off consumption for several clocks, and it must not drop, duplicate or reorder a group. The bench holds out_ready low while it forms six single-instruction groups with distinct tags. It then presents a seventh entry with a tag not used before and lets clocks pass. Finally it drains the queue and expects exactly the six original tags in order, followed by an empty queue. Pair packing with a zero-op first instruction is a second corner case, and it is reached by giving the first tag low bits of 0.

// File: rtl/mds_pkg.sv
package mds_pkg;
  localparam int SLOTS = 4;

  localparam logic [1:0] PATH_SHORT  = 2'd0;
  localparam logic [1:0] PATH_LONG   = 2'd1;
  localparam logic [1:0] PATH_VECTOR = 2'd2;

  localparam logic [1:0] CLS_COMMON  = 2'd0;
  localparam logic [1:0] CLS_SEMI    = 2'd1;
  localparam logic [1:0] CLS_COMPLEX = 2'd2;
  localparam logic [1:0] CLS_SERIAL  = 2'd3;
endpackage

// File: rtl/mds_classify.sv
module mds_classify
  import mds_pkg::*;
#(
  parameter int LEN_W     = 4,
  parameter int TAG_W     = 4,
  parameter int SHORT_MAX = 7,
  parameter int LONG_MAX  = 11
) (
  input  logic [LEN_W-1:0] len,
  input  logic [1:0]       cls,
  input  logic [TAG_W-1:0] tag,
  output logic [1:0]       path,
  output logic [2:0]       nops
);
  localparam logic [LEN_W-1:0] SMAX = LEN_W'(SHORT_MAX);
  localparam logic [LEN_W-1:0] LMAX = LEN_W'(LONG_MAX);

  always_comb begin
    if (len == '0 || cls == CLS_COMPLEX || cls == CLS_SERIAL)
      path = PATH_VECTOR;
    else if (cls == CLS_COMMON && len <= SMAX)
      path = PATH_SHORT;
    else if (cls == CLS_COMMON && len <= LMAX)
      path = PATH_LONG;
    else if (cls == CLS_SEMI && len <= SMAX)
      path = PATH_LONG;
    else
      path = PATH_VECTOR;
  end

  always_comb begin
    unique case (path)
      PATH_SHORT: nops = (tag[1:0] == 2'd3) ? 3'd2 : {1'b0, tag[1:0]};
      PATH_LONG:  nops = {1'b0, tag[1:0]} + 3'd1;
      default:    nops = 3'd4;
    endcase
  end
endmodule

// File: rtl/mds_build.sv
module mds_build
  import mds_pkg::*;
#(
  parameter int TAG_W = 4,
  localparam int UOP_W = TAG_W + 4
) (
  input  logic                   pair,
  input  logic [1:0]             path0,
  input  logic [2:0]             n0,
  input  logic [TAG_W-1:0]       tag0,
  input  logic [2:0]             n1,
  input  logic [TAG_W-1:0]       tag1,
  output logic [SLOTS*UOP_W-1:0] ops
);
  logic vec0;
  assign vec0 = (path0 == PATH_VECTOR);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam logic [2:0] SI = 3'(s);
    logic [2:0] idx1;
    assign idx1 = SI - n0;
    always_comb begin
      if (SI < n0)
        ops[s*UOP_W +: UOP_W] = {1'b1, vec0, tag0, SI[1:0]};
      else if (pair && idx1 < n1)
        ops[s*UOP_W +: UOP_W] = {1'b1, 1'b0, tag1, idx1[1:0]};
      else
        ops[s*UOP_W +: UOP_W] = '0;
    end
  end
endmodule

// File: rtl/mds_queue.sv
module mds_queue #(
  parameter int W     = 34,
  parameter int DEPTH = 6,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;

  assign dout = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/mpath_decode_sel.sv
module mpath_decode_sel
  import mds_pkg::*;
#(
  parameter int LEN_W     = 4,
  parameter int TAG_W     = 4,
  parameter int SHORT_MAX = 7,
  parameter int LONG_MAX  = 11,
  parameter int DEPTH     = 6,
  localparam int UOP_W = TAG_W + 4,
  localparam int GRP_W = SLOTS * UOP_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in0_valid,
  input  logic [LEN_W-1:0] in0_len,
  input  logic [1:0]       in0_cls,
  input  logic [TAG_W-1:0] in0_tag,
  output logic             in0_ready,
  input  logic             in1_valid,
  input  logic [LEN_W-1:0] in1_len,
  input  logic [1:0]       in1_cls,
  input  logic [TAG_W-1:0] in1_tag,
  output logic             in1_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [GRP_W-1:0] out_ops,
  output logic [1:0]       out_path
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [LEN_W-1:0] e_len [2];
  logic [1:0]       e_cls [2];
  logic [TAG_W-1:0] e_tag [2];
  logic [1:0]       e_path [2];
  logic [2:0]       e_n [2];

  assign e_len[0] = in0_len;  assign e_cls[0] = in0_cls;  assign e_tag[0] = in0_tag;
  assign e_len[1] = in1_len;  assign e_cls[1] = in1_cls;  assign e_tag[1] = in1_tag;

  for (genvar e = 0; e < 2; e++) begin : g_entry
    mds_classify #(
      .LEN_W(LEN_W), .TAG_W(TAG_W), .SHORT_MAX(SHORT_MAX), .LONG_MAX(LONG_MAX)
    ) u_cls (
      .len(e_len[e]), .cls(e_cls[e]), .tag(e_tag[e]),
      .path(e_path[e]), .nops(e_n[e])
    );
  end

  logic             full, both_short, pair, push;
  logic [GRP_W-1:0] grp_ops;
  logic [CNT_W-1:0] q_count;
  logic [GRP_W+1:0] q_dout;

  assign full       = (q_count == FULL_CNT);
  assign both_short = (e_path[0] == PATH_SHORT) && (e_path[1] == PATH_SHORT);
  assign pair       = in0_valid && in1_valid && both_short && !full;
  assign push       = in0_valid && !full;
  assign in0_ready  = !full;
  assign in1_ready  = !full && in0_valid && both_short;

  mds_build #(.TAG_W(TAG_W)) u_build (
    .pair(pair), .path0(e_path[0]), .n0(e_n[0]), .tag0(e_tag[0]),
    .n1(e_n[1]), .tag1(e_tag[1]), .ops(grp_ops)
  );

  mds_queue #(.W(GRP_W + 2), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(push), .din({e_path[0], grp_ops}),
    .pop(out_valid && out_ready), .dout(q_dout), .count(q_count)
  );

  assign out_valid = (q_count != '0);
  assign out_ops   = q_dout[GRP_W-1:0];
  assign out_path  = q_dout[GRP_W+1:GRP_W];
endmodule

// File: rtl/mds_checker.sv
module mds_checker
  import mds_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int DEPTH = 6,
  localparam int UOP_W = TAG_W + 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in0_valid,
  input logic                   in0_ready,
  input logic                   in1_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [SLOTS*UOP_W-1:0] out_ops,
  input logic [1:0]             out_path,
  input logic [CNT_W-1:0]       q_count
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic all_seq;
  always_comb begin
    all_seq = 1'b1;
    for (int k = 0; k < SLOTS; k++)
      if (out_ops[k*UOP_W + UOP_W - 2 +: 2] != 2'b11) all_seq = 1'b0;
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= FULL_CNT);

  assert_stall_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == FULL_CNT) |-> (!in0_ready && !in1_ready));

  assert_pair_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in1_ready |-> (in0_ready && in0_valid));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ops) && $stable(out_path)));

  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count > $past(q_count)) |-> (q_count == $past(q_count) + 1'b1));

  assert_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_path == PATH_VECTOR) |-> all_seq);

  for (genvar k = 0; k < SLOTS - 1; k++) begin : g_pad
    assert_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ops[k*UOP_W +: UOP_W] == '0) |-> (out_ops[(k+1)*UOP_W +: UOP_W] == '0));
  end
endmodule

bind mpath_decode_sel mds_checker #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in0_valid(in0_valid), .in0_ready(in0_ready),
  .in1_ready(in1_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_ops(out_ops), .out_path(out_path), .q_count(q_count)
);

// File: tb/sim_mpath_decode_sel.sv
module sim_mpath_decode_sel;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in0_valid = 0, in1_valid = 0, out_ready = 0;
  logic [3:0] in0_len = 0, in1_len = 0, in0_tag = 0, in1_tag = 0;
  logic [1:0] in0_cls = 0, in1_cls = 0;
  logic in0_ready, in1_ready, out_valid;
  logic [31:0] out_ops;
  logic [1:0] out_path;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  mpath_decode_sel u0 (
    .clk(clk), .rst_n(rst_n),
    .in0_valid(in0_valid), .in0_len(in0_len), .in0_cls(in0_cls), .in0_tag(in0_tag), .in0_ready(in0_ready),
    .in1_valid(in1_valid), .in1_len(in1_len), .in1_cls(in1_cls), .in1_tag(in1_tag), .in1_ready(in1_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_ops(out_ops), .out_path(out_path)
  );

  function automatic logic [1:0] m_path(logic [3:0] len, logic [1:0] cls);
    if (len == 0 || cls >= 2) return 2'd2;
    if (cls == 0 && len <= 7) return 2'd0;
    if (cls == 0 && len <= 11) return 2'd1;
    if (cls == 1 && len <= 7) return 2'd1;
    return 2'd2;
  endfunction

  function automatic int m_n(logic [1:0] p, logic [3:0] tag);
    if (p == 2'd0) return (tag[1:0] == 3) ? 2 : int'(tag[1:0]);
    if (p == 2'd1) return int'(tag[1:0]) + 1;
    return 4;
  endfunction

  function automatic logic [31:0] m_group(logic pr, logic [1:0] p0, logic [3:0] t0, logic [1:0] p1, logic [3:0] t1);
    logic [31:0] g = '0;
    int s = 0;
    for (int k = 0; k < m_n(p0, t0); k++) begin
      g[s*8 +: 8] = {1'b1, p0 == 2'd2, t0, 2'(k)}; s++;
    end
    if (pr)
      for (int k = 0; k < m_n(p1, t1); k++) begin
        g[s*8 +: 8] = {1'b1, 1'b0, t1, 2'(k)}; s++;
      end
    return g;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pop_one();
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    out_ready = 0;
  endtask

  // One window, one clock; checks readies, the formed group, then drains it.
  task automatic t_one(input string req, input logic [3:0] l0, input logic [1:0] c0, input logic [3:0] t0,
                       input logic v1, input logic [3:0] l1, input logic [1:0] c1, input logic [3:0] t1);
    logic [1:0] p0, p1;
    logic pr;
    logic [31:0] eg;
    p0 = m_path(l0, c0); p1 = m_path(l1, c1);
    pr = v1 && p0 == 2'd0 && p1 == 2'd0;
    eg = m_group(pr, p0, t0, p1, t1);
    @(negedge clk);
    in0_valid = 1; in0_len = l0; in0_cls = c0; in0_tag = t0;
    in1_valid = v1; in1_len = l1; in1_cls = c1; in1_tag = t1;
    #1;
    chk(in0_ready == 1, req, 32'(in0_ready), 32'd1);
    chk(in1_ready == pr, req, 32'(in1_ready), 32'(pr));
    @(posedge clk); @(negedge clk);
    in0_valid = 0; in1_valid = 0;
    chk(out_valid == 1, req, 32'(out_valid), 32'd1);
    chk(out_ops == eg, req, out_ops, eg);
    chk(out_path == p0, req, 32'(out_path), 32'(p0));
    pop_one();
    chk(out_valid == 0, req, 32'(out_valid), 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 0, "R9", 32'(out_valid), 0);
    chk(in0_ready == 1, "R9", 32'(in0_ready), 1);
  endtask

  task automatic t_ignore_in1();  // R10
    @(negedge clk);
    in0_valid = 0; in1_valid = 1; in1_len = 2; in1_cls = 0; in1_tag = 4'h5;
    #1;
    chk(in1_ready == 0, "R10", 32'(in1_ready), 0);
    @(posedge clk); @(negedge clk);
    in1_valid = 0;
    chk(out_valid == 0, "R10", 32'(out_valid), 0);
  endtask

  task automatic t_full();  // R7 and R8
    logic [31:0] eg;
    out_ready = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      in0_valid = 1; in0_len = 3; in0_cls = 0; in0_tag = 4'(i); in1_valid = 0;
      @(posedge clk);
    end
    @(negedge clk);
    in0_tag = 4'hF; in1_valid = 1; in1_len = 2; in1_cls = 0; in1_tag = 4'hE;
    #1;
    chk(in0_ready == 0, "R7", 32'(in0_ready), 0);
    chk(in1_ready == 0, "R7", 32'(in1_ready), 0);
    eg = m_group(0, 2'd0, 4'd1, 2'd0, 4'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_ops == eg, "R8", out_ops, eg);
    in0_valid = 0; in1_valid = 0;
    for (int i = 1; i <= 6; i++) begin
      eg = m_group(0, 2'd0, 4'(i), 2'd0, 4'd0);
      chk(out_valid == 1, "R7", 32'(out_valid), 1);
      chk(out_ops == eg, "R8", out_ops, eg);
      pop_one();
    end
    chk(out_valid == 0, "R7", 32'(out_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_one("R1", 4'd3, 2'd0, 4'h5, 0, 0, 0, 0);
    t_one("R1", 4'd7, 2'd0, 4'h3, 0, 0, 0, 0);
    t_one("R1", 4'd1, 2'd0, 4'h4, 0, 0, 0, 0);
    t_one("R2", 4'd2, 2'd0, 4'h6, 1, 4'd5, 2'd0, 4'hA);
    t_one("R2", 4'd4, 2'd0, 4'h4, 1, 4'd6, 2'd0, 4'h9);
    t_one("R3", 4'd2, 2'd0, 4'h5, 1, 4'd9, 2'd0, 4'h1);
    t_one("R3", 4'd9, 2'd0, 4'h1, 1, 4'd2, 2'd0, 4'h5);
    t_one("R4", 4'd8, 2'd0, 4'h7, 0, 0, 0, 0);
    t_one("R6", 4'd11, 2'd0, 4'h2, 0, 0, 0, 0);
    t_one("R4", 4'd6, 2'd1, 4'h0, 0, 0, 0, 0);
    t_one("R5", 4'd3, 2'd2, 4'hC, 0, 0, 0, 0);
    t_one("R5", 4'd12, 2'd0, 4'h1, 0, 0, 0, 0);
    t_one("R5", 4'd9, 2'd1, 4'h2, 0, 0, 0, 0);
    t_one("R5", 4'd1, 2'd3, 4'h8, 1, 4'd2, 2'd0, 4'h1);
    t_one("R5", 4'd0, 2'd0, 4'h3, 0, 0, 0, 0);
    t_ignore_in1();
    t_full();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule